// File: doc/BRIEF.md
# Host Command Bus-Hold Arbiter

This block sits between a debug host's command stream and a memory bus that other masters share. The host gives no advance notice of an access and has no flow control. The block therefore raises a bus-hold request as soon as any command completes. It keeps that request up with an inactivity countdown, so a burst of back-to-back commands is covered by one long hold. There is no per-transfer request/grant exchange.

Each completed command reloads the countdown to its maximum. Each pulse of serial traffic activity (`shift_tick`) lowers the countdown by one. When the count reaches zero, the automatic hold drops. A command that reads or writes memory marks a memory-operation flag. The memory access state machine is allowed to run only when that flag is set and the synchronized hold acknowledge is present. A manual hold switch can force the request on. A build parameter removes the automatic path, and the manual switch is then the only source of the request.

Top module: `cmd_bus_hold_arb`

## Requirements
- R1: While reset is applied, `hold_req` equals `manual_hold`, and `mem_op` and `sm_en` are 0. The countdown is zero.
- R2: With automatic hold built in, a `cmd_stb` pulse loads the countdown with `TMR_MAX`, and `hold_req` is 1 from the next cycle on.
- R3: A `shift_tick` without `cmd_stb` lowers a non-zero countdown by one. `hold_req` stays 1 from automatic hold until exactly `TMR_MAX` such ticks have followed the last command, and falls in the cycle after the last of them.
- R4: When `cmd_stb` and `shift_tick` arrive in the same cycle, the reload wins, and the countdown becomes `TMR_MAX`.
- R5: On every `cmd_stb`, `mem_op` takes the value of `cmd_is_mem` (1 = memory read or write) from the next cycle on. With automatic hold built in, `mem_op` is cleared in the cycle where the countdown reaches zero.
- R6: `sm_en` is 1 exactly when `mem_op` is 1 and `hold_ack`, delayed by the two-stage synchronizer (two clock edges), is 1.
- R7: `manual_hold` = 1 forces `hold_req` to 1 in the same cycle, whatever the countdown holds.
- R8: With automatic hold left out (`AUTO_HOLD` = 0), `hold_req` follows `manual_hold` only, and commands do not raise it.
- R9: A `shift_tick` while the countdown is zero leaves it at zero, with no wrap to the maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_stb | input | 1 | One-cycle pulse per completed host command |
| cmd_is_mem | input | 1 | Qualifies `cmd_stb`: 1 = memory read or write command |
| shift_tick | input | 1 | Pulse per unit of host serial traffic; steps the countdown |
| hold_ack | input | 1 | Asynchronous bus-hold acknowledge from the bus owner |
| manual_hold | input | 1 | Manual switch that forces the hold request |
| hold_req | output | 1 | Bus-hold request |
| mem_op | output | 1 | Memory-operation flag |
| sm_en | output | 1 | Enable for the memory access state machine |

## Verification
The bench builds two instances from the same stimulus. The first has automatic hold, a 4-bit countdown and a maximum of 11. The small counter lets every expiry, the reload-over-tick collision and ticks at zero all occur many times inside a short run. A maximum other than all ones shows that the parameter, and not the counter width, sets the hold length. The second instance is built without automatic hold. It is exposed to the same commands, which shows that commands have no effect on its request.

// File: rtl/cmd_bus_hold_arb_pkg.sv
package cmd_bus_hold_arb_pkg;

  // Action the countdown takes on the next clock edge
  typedef enum logic [1:0] {
    TMR_KEEP = 2'd0,
    TMR_LOAD = 2'd1,
    TMR_DEC  = 2'd2
  } tmr_op_e;

  localparam int unsigned MIN_SYNC_STAGES = 2;

endpackage

// File: rtl/hba_rst_sync.sv
module hba_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/hba_bit_sync.sv
module hba_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign q_o = sync_q[STAGES-1];

endmodule

// File: rtl/hba_hold_timer.sv
module hba_hold_timer
  import cmd_bus_hold_arb_pkg::*;
#(
  parameter int unsigned        TMR_W   = 16,
  parameter logic [TMR_W-1:0]   TMR_MAX = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             tick_i,
  output logic [TMR_W-1:0] count_o,
  output logic             active_o,
  output logic             expire_o
);

  localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

  tmr_op_e          op;
  logic [TMR_W-1:0] count_q;
  logic [TMR_W-1:0] count_d;
  logic             nonzero;

  assign nonzero = |count_q;

  // Reload takes priority over a decrement in the same cycle
  always_comb begin
    if (load_i) begin
      op = TMR_LOAD;
    end else if (tick_i && nonzero) begin
      op = TMR_DEC;
    end else begin
      op = TMR_KEEP;
    end
  end

  always_comb begin
    unique case (op)
      TMR_LOAD: count_d = TMR_MAX;
      TMR_DEC:  count_d = count_q - ONE;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else if (op != TMR_KEEP) begin
      count_q <= count_d;
    end
  end

  assign count_o  = count_q;
  assign active_o = nonzero;
  assign expire_o = (op == TMR_DEC) && (count_q == ONE);

endmodule

// File: rtl/cmd_bus_hold_arb.sv
module cmd_bus_hold_arb
  import cmd_bus_hold_arb_pkg::*;
#(
  parameter int unsigned      TMR_W       = 16,
  parameter logic [TMR_W-1:0] TMR_MAX     = '1,
  parameter bit               AUTO_HOLD   = 1'b1,
  parameter int unsigned      SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_stb,
  input  logic cmd_is_mem,
  input  logic shift_tick,
  input  logic hold_ack,
  input  logic manual_hold,
  output logic hold_req,
  output logic mem_op,
  output logic sm_en
);

  localparam int unsigned N_SYNC =
    (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;

  logic             rst_sync_n;
  logic             ack_s;
  logic [TMR_W-1:0] tmr_q;
  logic             auto_active;
  logic             tmr_expire;
  logic             mem_op_q;
  logic             mem_op_d;
  logic             mem_op_en;

  hba_rst_sync #(.STAGES(N_SYNC)) u_rst_sync (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_sync_n)
  );

  hba_bit_sync #(.STAGES(N_SYNC)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   (hold_ack),
    .q_o   (ack_s)
  );

  generate
    if (AUTO_HOLD) begin : g_auto
      hba_hold_timer #(.TMR_W(TMR_W), .TMR_MAX(TMR_MAX)) u_timer (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .load_i   (cmd_stb),
        .tick_i   (shift_tick),
        .count_o  (tmr_q),
        .active_o (auto_active),
        .expire_o (tmr_expire)
      );
    end else begin : g_manual_only
      assign tmr_q       = '0;
      assign auto_active = 1'b0;
      assign tmr_expire  = 1'b0;
    end
  endgenerate

  // Memory-operation flag: loaded per command, dropped on hold expiry
  always_comb begin
    mem_op_en = cmd_stb | tmr_expire;
    if (cmd_stb) begin
      mem_op_d = cmd_is_mem;
    end else begin
      mem_op_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      mem_op_q <= 1'b0;
    end else if (mem_op_en) begin
      mem_op_q <= mem_op_d;
    end
  end

  assign hold_req = manual_hold | auto_active;
  assign mem_op   = mem_op_q;
  assign sm_en    = ack_s & mem_op_q;

endmodule

// File: rtl/cmd_bus_hold_arb_chk.sv
module cmd_bus_hold_arb_chk #(
  parameter int unsigned      TMR_W     = 16,
  parameter logic [TMR_W-1:0] TMR_MAX   = '1,
  parameter bit               AUTO_HOLD = 1'b1
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             cmd_stb,
  input logic             cmd_is_mem,
  input logic             shift_tick,
  input logic             manual_hold,
  input logic             hold_req,
  input logic             mem_op,
  input logic             sm_en,
  input logic [TMR_W-1:0] tmr_q
);

  // R2
  hold_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (AUTO_HOLD && cmd_stb) |=> (hold_req && tmr_q == TMR_MAX));

  // R4
  reload_prio_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (AUTO_HOLD && cmd_stb && shift_tick) |=> (tmr_q == TMR_MAX));

  // R3
  tmr_step_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cmd_stb && shift_tick && tmr_q != '0) |=> (tmr_q == TMR_W'($past(tmr_q) - 1'b1)));

  // R9
  tmr_floor_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cmd_stb && tmr_q == '0) |=> (tmr_q == '0));

  // R5
  mem_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_stb |=> (mem_op == $past(cmd_is_mem)));

  // R6
  sm_gate_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sm_en |-> mem_op);

  // R7
  manual_force_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    manual_hold |-> hold_req);

  // R8
  manual_only_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!AUTO_HOLD && !manual_hold) |-> !hold_req);

endmodule

bind cmd_bus_hold_arb cmd_bus_hold_arb_chk #(
  .TMR_W     (TMR_W),
  .TMR_MAX   (TMR_MAX),
  .AUTO_HOLD (AUTO_HOLD)
) u_chk (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .cmd_stb     (cmd_stb),
  .cmd_is_mem  (cmd_is_mem),
  .shift_tick  (shift_tick),
  .manual_hold (manual_hold),
  .hold_req    (hold_req),
  .mem_op      (mem_op),
  .sm_en       (sm_en),
  .tmr_q       (tmr_q)
);

// File: tb/sim_cmd_bus_hold_arb.sv
module sim_cmd_bus_hold_arb;

  localparam int unsigned      B_W   = 4;
  localparam logic [B_W-1:0]   B_MAX = 4'd11;
  localparam int               LIMIT = 200000;

  logic clk = 1'b0;
  logic rst_n;
  logic cmd_stb, cmd_is_mem, shift_tick, hold_ack, manual_hold;
  logic h0, m0, s0, h1, m1, s1;

  int n_cmp = 0;
  int n_bad = 0;
  int m_t   = 0;
  bit m_mem0 = 1'b0;
  bit m_mem1 = 1'b0;
  bit [1:0] m_ack = 2'b00;

  always #4 clk = ~clk;

  cmd_bus_hold_arb #(.TMR_W(B_W), .TMR_MAX(B_MAX), .AUTO_HOLD(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_is_mem(cmd_is_mem),
    .shift_tick(shift_tick), .hold_ack(hold_ack), .manual_hold(manual_hold),
    .hold_req(h0), .mem_op(m0), .sm_en(s0)
  );

  cmd_bus_hold_arb #(.TMR_W(B_W), .TMR_MAX(B_MAX), .AUTO_HOLD(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_is_mem(cmd_is_mem),
    .shift_tick(shift_tick), .hold_ack(hold_ack), .manual_hold(manual_hold),
    .hold_req(h1), .mem_op(m1), .sm_en(s1)
  );

  function automatic bit exp_hold(input bit auto_on, input bit man, input int t);
    return man | (auto_on && t != 0);
  endfunction

  function automatic bit exp_sm(input bit [1:0] ack_pipe, input bit mem);
    return ack_pipe[1] & mem;
  endfunction

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Drive one cycle of inputs, compare outputs, then advance the model by one edge
  task automatic step(input string tg, input bit stb, input bit mem, input bit tk,
                      input bit ack, input bit man);
    @(negedge clk);
    cmd_stb = stb; cmd_is_mem = mem; shift_tick = tk; hold_ack = ack; manual_hold = man;
    #1;
    chk(tg, "u0.hold_req", h0, exp_hold(1'b1, man, m_t));
    chk(tg, "u0.mem_op",   m0, m_mem0);
    chk(tg, "u0.sm_en",    s0, exp_sm(m_ack, m_mem0));
    chk({tg, "/R8"}, "u1.hold_req", h1, exp_hold(1'b0, man, 0));
    chk(tg, "u1.mem_op",   m1, m_mem1);
    chk(tg, "u1.sm_en",    s1, exp_sm(m_ack, m_mem1));
    if (rst_n) begin
      if (stb) begin
        m_t = int'(B_MAX);
        m_mem0 = mem;
      end else if (tk && m_t != 0) begin
        m_t--;
        if (m_t == 0) m_mem0 = 1'b0;
      end
      if (stb) m_mem1 = mem;
      m_ack = {m_ack[0], ack};
    end
  endtask

  task automatic summary;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(LIMIT * 8);
    n_bad++;
    $display("FAIL watchdog expired at %0t", $time);
    summary();
    $finish;
  end

  initial begin
    int unsigned seed_dummy;
    bit r_ack = 1'b0;
    bit r_man = 1'b0;
    seed_dummy = $urandom(32'd20240611);
    rst_n = 1'b0;
    cmd_stb = 0; cmd_is_mem = 0; shift_tick = 0; hold_ack = 0; manual_hold = 0;

    // R1: reset state, even with traffic applied
    for (int i = 0; i < 3; i++) step("R1", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R1", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step("R1", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R2/R3/R5: memory command, then count down to expiry
    step("R2", 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < int'(B_MAX); i++) step("R3", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R5", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // R9: ticks at zero do not wrap
    for (int i = 0; i < 3; i++) step("R9", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R4: reload and tick together
    step("R4", 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step("R4", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    step("R4", 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < int'(B_MAX) + 2; i++) step("R4", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

    // R6: acknowledge through synchronizer gates the state machine
    step("R6", 1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    step("R6", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) step("R6", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);

    // R7: manual switch forces the request with an expired timer
    for (int i = 0; i < int'(B_MAX) + 1; i++) step("R7", 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R7", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);

    // Random traffic covering all requirements together
    for (int i = 0; i < 4000; i++) begin
      bit stb, mem, tk;
      stb = ($urandom % 9) == 0;
      mem = $urandom % 2;
      tk  = ($urandom % 3) != 0;
      if (($urandom % 7) == 0)  r_ack = ~r_ack;
      if (($urandom % 40) == 0) r_man = ~r_man;
      step("R2/R3/R5/R6", stb, mem, tk, r_ack, r_man);
    end

    summary();
    $finish;
  end

endmodule